// File: doc/BRIEF.md
# Three-Phase Power Combiner with Reverse-Power Flag

This block takes three signed real-power words, one for each phase of a polyphase meter, and reduces them to a single total. That total feeds the pulse-rate converter that follows. A mode input selects how the phases are combined. In one mode the signed values are added, so opposing flows cancel. In the other mode their magnitudes are added, so energy counts forward whatever its direction. The total is registered, and it is wide enough that three full-scale inputs can never wrap.

The block also drives a reverse-power indicator. It sets that indicator when any phase carries negative power, which means the current on that phase lags or leads its voltage by more than a quarter cycle. Each phase has an idle input from the no-load detector. A phase whose idle input is high is left out of the sign test, so creep-level noise on an unloaded phase cannot raise the indicator. The indicator is re-evaluated only on cycles where the calibration pulse strobe is high, and it keeps its value on all other cycles.

Reset is asynchronous and active low. Its release is synchronised inside the block, so registers leave reset two clock edges after `rst_n` rises.

Top module: `pwr_tri_combine`

## Requirements
- R1: When `sum_signed_i` is 1, `total_o` equals the two's-complement sum of the three phase words. Phase i occupies bits [i*PWR_W +: PWR_W] of `phase_pwr_i`.
- R2: When `sum_signed_i` is 0, `total_o` equals the sum of the absolute values of the three phase words.
- R3: `total_o` is PWR_W + clog2(NUM_PH+1) bits wide, which is 26 bits at the defaults. Three copies of the most negative or the most positive input give the exact result in both modes. In magnitude mode the total is never negative.
- R4: `total_o` reflects the inputs sampled at the previous rising clock edge. Changing the inputs between edges has no effect until the next edge.
- R5: On a clock edge where `cal_pulse_i` is 1, `rev_flag_o` becomes 1 if any phase has its sign bit set while its idle bit is 0. Idle bit i belongs to phase i.
- R6: On a clock edge where `cal_pulse_i` is 1 and no non-idle phase is negative, `rev_flag_o` becomes 0. A phase value of zero counts as not negative. The flag does not latch.
- R7: On clock edges where `cal_pulse_i` is 0, `rev_flag_o` keeps its value.
- R8: A phase whose idle bit is 1 is ignored by the reverse-power test but still contributes to `total_o`.
- R9: The reverse-power test behaves the same whether `sum_signed_i` is 0 or 1.
- R10: While `rst_n` is low, `total_o` is 0 and `rev_flag_o` is 0. Both clear at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_pwr_i | input | NUM_PH*PWR_W | Packed signed per-phase real power, phase 0 in the low bits |
| idle_i | input | NUM_PH | Per-phase no-load indication, bit i for phase i |
| sum_signed_i | input | 1 | 1: signed sum, 0: sum of magnitudes |
| cal_pulse_i | input | 1 | Calibration pulse strobe that gates flag updates |
| total_o | output | PWR_W+clog2(NUM_PH+1) | Registered combined power, two's complement |
| rev_flag_o | output | 1 | Reverse-power indicator |

## Verification
The summing path and the flag path share their inputs and are updated on the same edge. A strobe cycle therefore changes both outputs at once, under whichever summing mode is active. The bench places strobes on cycles where the mode is switched, where a negative phase is masked as idle, and where the inputs are at full scale. At the following sample point it compares both the new total and the new flag against values worked out by hand. Vectors with the strobe low then confirm that the total keeps tracking the inputs while the flag holds.

// File: rtl/pwr_tri_pkg.sv
package pwr_tri_pkg;

  typedef enum logic {
    SUM_MAGNITUDE = 1'b0,
    SUM_SIGNED    = 1'b1
  } sum_mode_e;

  // Width of a total that holds NUM_PH full-scale magnitudes without wrapping.
  function automatic int total_width(input int pwr_w, input int num_ph);
    return pwr_w + $clog2(num_ph + 1);
  endfunction

endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pwr_phase_cond.sv
module pwr_phase_cond
  import pwr_tri_pkg::*;
#(
  parameter int PWR_W = 24,
  parameter int TOT_W = 26
) (
  input  logic [PWR_W-1:0] pwr_i,
  input  logic             idle_i,
  input  sum_mode_e        mode_i,
  output logic [TOT_W-1:0] contrib_o,
  output logic             neg_live_o
);

  localparam int EXT_W = TOT_W - PWR_W;

  logic             sign_bit;
  logic [TOT_W-1:0] sext;
  logic [TOT_W-1:0] mag;

  always_comb begin
    sign_bit = pwr_i[PWR_W-1];
    sext     = {{EXT_W{sign_bit}}, pwr_i};
    // Negation in the wider format keeps the most negative input exact.
    mag      = sign_bit ? ((~sext) + TOT_W'(1)) : sext;
    if (mode_i == SUM_SIGNED) begin
      contrib_o = sext;
    end else begin
      contrib_o = mag;
    end
    neg_live_o = sign_bit & ~idle_i;
  end

endmodule

// File: rtl/pwr_sum_reg.sv
module pwr_sum_reg #(
  parameter int NUM_PH = 3,
  parameter int TOT_W  = 26
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en_i,
  input  logic [NUM_PH*TOT_W-1:0] contrib_i,
  output logic [TOT_W-1:0]        total_o
);

  logic [TOT_W-1:0] sum_d;
  logic [TOT_W-1:0] total_q;
  logic [TOT_W-1:0] total_d;

  always_comb begin
    sum_d = '0;
    for (int i = 0; i < NUM_PH; i++) begin
      sum_d = sum_d + contrib_i[i*TOT_W +: TOT_W];
    end
    total_d = en_i ? sum_d : total_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q <= '0;
    end else begin
      total_q <= total_d;
    end
  end

  assign total_o = total_q;

endmodule

// File: rtl/pwr_rev_flag.sv
module pwr_rev_flag #(
  parameter int NUM_PH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_i,
  input  logic [NUM_PH-1:0] neg_live_i,
  output logic              flag_o
);

  logic flag_q;
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (cal_i) begin
      flag_d = |neg_live_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/pwr_tri_combine.sv
module pwr_tri_combine
  import pwr_tri_pkg::*;
#(
  parameter int PWR_W  = 24,
  parameter int NUM_PH = 3,
  parameter int TOT_W  = total_width(PWR_W, NUM_PH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_PH*PWR_W-1:0] phase_pwr_i,
  input  logic [NUM_PH-1:0]       idle_i,
  input  logic                    sum_signed_i,
  input  logic                    cal_pulse_i,
  output logic [TOT_W-1:0]        total_o,
  output logic                    rev_flag_o
);

  logic                    rst_sync_n;
  logic [NUM_PH*TOT_W-1:0] contrib;
  logic [NUM_PH-1:0]       neg_live;
  sum_mode_e               mode;

  assign mode = sum_mode_e'(sum_signed_i);

  pwr_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar g = 0; g < NUM_PH; g++) begin : g_phase
    pwr_phase_cond #(.PWR_W(PWR_W), .TOT_W(TOT_W)) u_cond (
      .pwr_i      (phase_pwr_i[g*PWR_W +: PWR_W]),
      .idle_i     (idle_i[g]),
      .mode_i     (mode),
      .contrib_o  (contrib[g*TOT_W +: TOT_W]),
      .neg_live_o (neg_live[g])
    );
  end

  pwr_sum_reg #(.NUM_PH(NUM_PH), .TOT_W(TOT_W)) u_sum (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en_i      (1'b1),
    .contrib_i (contrib),
    .total_o   (total_o)
  );

  pwr_rev_flag #(.NUM_PH(NUM_PH)) u_flag (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cal_i      (cal_pulse_i),
    .neg_live_i (neg_live),
    .flag_o     (rev_flag_o)
  );

endmodule

// File: rtl/pwr_tri_combine_chk.sv
module pwr_tri_combine_chk #(
  parameter int PWR_W  = 24,
  parameter int NUM_PH = 3,
  parameter int TOT_W  = 26
) (
  input logic                    clk,
  input logic                    rst_sync_n,
  input logic [NUM_PH*PWR_W-1:0] phase_pwr_i,
  input logic [NUM_PH-1:0]       idle_i,
  input logic                    sum_signed_i,
  input logic                    cal_pulse_i,
  input logic [TOT_W-1:0]        total_o,
  input logic                    rev_flag_o
);

  logic signed [TOT_W-1:0] exp_arith;
  logic signed [TOT_W-1:0] exp_mag;
  logic                    live_neg;

  always_comb begin
    exp_arith = '0;
    exp_mag   = '0;
    live_neg  = 1'b0;
    for (int i = 0; i < NUM_PH; i++) begin
      logic signed [TOT_W-1:0] w;
      w = TOT_W'($signed(phase_pwr_i[i*PWR_W +: PWR_W]));
      exp_arith = exp_arith + w;
      exp_mag   = exp_mag + ((w < 0) ? -w : w);
      if ((w < 0) && !idle_i[i]) live_neg = 1'b1;
    end
  end

  AST_SUM_SIGNED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sum_signed_i |=> ($signed(total_o) == $past(exp_arith))); // R1

  AST_SUM_MAGNITUDE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !sum_signed_i |=> ($signed(total_o) == $past(exp_mag))); // R2

  AST_MAG_NONNEG: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !sum_signed_i |=> !total_o[TOT_W-1]); // R3

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cal_pulse_i && live_neg) |=> rev_flag_o); // R5

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cal_pulse_i && !live_neg) |=> !rev_flag_o); // R6

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cal_pulse_i |=> $stable(rev_flag_o)); // R7

endmodule

bind pwr_tri_combine pwr_tri_combine_chk #(
  .PWR_W(PWR_W), .NUM_PH(NUM_PH), .TOT_W(TOT_W)
) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .phase_pwr_i  (phase_pwr_i),
  .idle_i       (idle_i),
  .sum_signed_i (sum_signed_i),
  .cal_pulse_i  (cal_pulse_i),
  .total_o      (total_o),
  .rev_flag_o   (rev_flag_o)
);

// File: tb/pwr_tri_combine_tb.sv
module pwr_tri_combine_tb;

  localparam int PWR_W  = 24;
  localparam int NUM_PH = 3;
  localparam int TOT_W  = 26;
  localparam int NVEC   = 14;

  typedef struct packed {
    logic signed [PWR_W-1:0] p0;
    logic signed [PWR_W-1:0] p1;
    logic signed [PWR_W-1:0] p2;
    logic [2:0]              idle;
    logic                    mode;
    logic                    cal;
    logic signed [TOT_W-1:0] tot;
    logic                    flag;
  } vec_t;

  // mode 1 = signed sum, 0 = magnitudes; idle bit i = phase i
  localparam vec_t VECS [NVEC] = '{
    '{ 24'sd100,  24'sd200,  24'sd300, 3'b000, 1'b1, 1'b1,  26'sd600,      1'b0}, // R1 R6
    '{ 24'sd100, -24'sd50,   24'sd20,  3'b000, 1'b1, 1'b0,  26'sd70,       1'b0}, // R1 R7
    '{ 24'sd100, -24'sd50,   24'sd20,  3'b000, 1'b1, 1'b1,  26'sd70,       1'b1}, // R5
    '{ 24'sd100, -24'sd50,   24'sd20,  3'b000, 1'b0, 1'b0,  26'sd170,      1'b1}, // R2 R7
    '{ 24'sd10,   24'sd20,   24'sd30,  3'b000, 1'b0, 1'b1,  26'sd60,       1'b0}, // R2 R6
    '{-24'sd5,    24'sd7,   -24'sd9,   3'b000, 1'b0, 1'b1,  26'sd21,       1'b1}, // R9
    '{-24'sd5,    24'sd7,   -24'sd9,   3'b000, 1'b1, 1'b0, -26'sd7,        1'b1}, // R1
    '{-24'sd40,   24'sd5,    24'sd5,   3'b001, 1'b1, 1'b1, -26'sd30,       1'b0}, // R8
    '{-24'sd40,   24'sd5,    24'sd5,   3'b000, 1'b1, 1'b1, -26'sd30,       1'b1}, // R5
    '{ 24'sd0,    24'sd0,    24'sd0,   3'b000, 1'b0, 1'b1,  26'sd0,        1'b0}, // R6
    '{24'sh800000, 24'sh800000, 24'sh800000, 3'b000, 1'b0, 1'b0,  26'sd25165824, 1'b0}, // R3
    '{24'sh800000, 24'sh800000, 24'sh800000, 3'b000, 1'b1, 1'b1, -26'sd25165824, 1'b1}, // R3
    '{24'sh7FFFFF, 24'sh7FFFFF, 24'sh7FFFFF, 3'b000, 1'b1, 1'b0,  26'sd25165821, 1'b1}, // R3
    '{-24'sd1,   -24'sd2,   -24'sd3,   3'b111, 1'b1, 1'b1, -26'sd6,        1'b0}  // R8
  };

  logic                    clk;
  logic                    rst_n;
  logic [NUM_PH*PWR_W-1:0] phase_pwr_i;
  logic [NUM_PH-1:0]       idle_i;
  logic                    sum_signed_i;
  logic                    cal_pulse_i;
  logic [TOT_W-1:0]        total_o;
  logic                    rev_flag_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  pwr_tri_combine u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .phase_pwr_i  (phase_pwr_i),
    .idle_i       (idle_i),
    .sum_signed_i (sum_signed_i),
    .cal_pulse_i  (cal_pulse_i),
    .total_o      (total_o),
    .rev_flag_o   (rev_flag_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic signed [31:0] act,
                     input logic signed [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic signed [PWR_W-1:0] a, b, c,
                       input logic [2:0] idl, input logic md, input logic cal);
    phase_pwr_i  = {c, b, a};
    idle_i       = idl;
    sum_signed_i = md;
    cal_pulse_i  = cal;
  endtask

  initial begin
    rst_n = 1'b0;
    drive(24'sd0, 24'sd0, 24'sd0, 3'b000, 1'b1, 1'b0);
    #10;
    chk("R10 total in reset", $signed(total_o), 0);
    chk("R10 flag in reset", {31'b0, rev_flag_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i].p0, VECS[i].p1, VECS[i].p2, VECS[i].idle, VECS[i].mode, VECS[i].cal);
      @(negedge clk);
      chk($sformatf("vec%0d total R1/R2/R3", i), $signed(total_o), 32'(VECS[i].tot));
      chk($sformatf("vec%0d flag R5/R6/R7/R8/R9", i), {31'b0, rev_flag_o}, {31'b0, VECS[i].flag});
    end

    // R4: new inputs do not show before the next rising edge
    drive(24'sd1, 24'sd2, 24'sd3, 3'b000, 1'b1, 1'b0);
    #2;
    chk("R4 total before edge", $signed(total_o), -6);
    @(negedge clk);
    chk("R4 total after edge", $signed(total_o), 6);

    // R10: asynchronous clear mid-operation
    drive(-24'sd1, 24'sd0, 24'sd0, 3'b000, 1'b1, 1'b1);
    @(negedge clk);
    chk("R5 flag before reset", {31'b0, rev_flag_o}, 1);
    chk("R1 total before reset", $signed(total_o), -1);
    cal_pulse_i = 1'b0;
    #1 rst_n = 1'b0;
    #1;
    chk("R10 async total clear", $signed(total_o), 0);
    chk("R10 async flag clear", {31'b0, rev_flag_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 flag holds after reset without strobe", {31'b0, rev_flag_o}, 0);
    chk("R1 total after reset release", $signed(total_o), -1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule